// File: doc/BRIEF.md
# I2C master byte engine

This block is the master half of an I2C controller. A single control write sets a master-enable bit and a three-bit rate code. When master-enable rises, the engine generates a START, shifts out a seven-bit calling address followed by the R/W bit, and samples the acknowledge on the ninth clock. It then shifts out each data byte that software has placed in the one-entry transmit register. SDA and SCL are open-drain, so the engine drives only pull-down enables. It reads SDA back to see the acknowledge.

A transfer can end in three ways. Writing master-enable to 0 lets the byte in flight finish, then generates a STOP and drops any queued byte. A missing acknowledge does the same and also sets a sticky NAK flag. An external transmit-fail input releases both lines on the next clock and generates no STOP. A one-cycle byte-done pulse after every ninth clock tells software when to load the next byte.

Top module: `i2c_mstr_engine`

## Requirements
- R1: After reset both line enables are 0 (lines released), and master-enable, the NAK flag and byte-done are 0.
- R2: A transfer begins with a START, which is SDA falling while SCL is high. The first byte is the calling address (MSB first) with the R/W bit as its last bit. Each later byte is the next queued data byte, MSB first. An enable of 1 pulls its line low.
- R3: The SCL period is 16 << rate system clocks, for rate codes 0 to 7 (16 to 2048 clocks).
- R4: Within a transfer, SDA changes only while SCL is low. The only exceptions are the single START edge and the single STOP edge (SDA rising while SCL is high).
- R5: byte_done is a one-cycle pulse, issued exactly once for each byte (address or data) after its ninth clock.
- R6: The acknowledge is sampled when the ninth SCL pulse rises. If SDA is high, the NAK flag is set, master-enable is cleared, a STOP follows, and any queued byte is never sent.
- R7: The NAK flag stays set until a nak_clr pulse clears it.
- R8: If master-enable is written to 0 during a transfer, the byte in flight completes, a STOP follows, and a byte queued but not yet started is discarded and never sent.
- R9: If no byte is queued when a byte ends and master-enable is still 1, the engine holds SCL low until a byte is written or master-enable is cleared.
- R10: A tx_fail pulse releases both lines and clears master-enable on the next clock, and no STOP is generated afterwards.
- R11: One control write loads both master-enable (ctl_master) and the rate code (ctl_rate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_master | input | 1 | Master-enable value written by ctl_wr |
| ctl_rate | input | 3 | Rate code written by ctl_wr |
| call_addr | input | 7 | Calling address |
| call_rw | input | 1 | R/W bit sent after the address |
| tx_wr | input | 1 | Transmit register write strobe |
| tx_data | input | 8 | Transmit byte |
| nak_clr | input | 1 | Clears the NAK flag |
| tx_fail | input | 1 | Abort: release lines immediately |
| sda_in | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| master | output | 1 | Master-enable bit |
| nakif | output | 1 | Sticky NAK flag |
| byte_done | output | 1 | Pulse after each ninth clock |

## Verification
The assertions assume the following about the inputs:
- sda_in is the wired-AND of the engine's own SDA and a slave that pulls low only in the acknowledge slot.
- tx_fail lasts a single cycle.
- The calling address and R/W inputs do not change during a transfer.

The bench satisfies these assumptions with a behavioural slave. It pulls SDA only between the eighth falling edge of SCL and the ninth falling edge, and it withholds the acknowledge on a chosen byte index. It fires tx_fail for exactly one cycle, and only while the engine is pulling both lines low, so the release cannot look like a STOP. It also changes the address only between transfers.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_BIT   = 3'd2,
    ST_WAIT  = 3'd3,
    ST_STOP  = 3'd4
  } seq_st_t;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int BASE_DIV = 16,
  parameter int RATE_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  output logic              qtick
);
  localparam int QBASE = BASE_DIV / 4;
  localparam int CNT_W = $clog2(QBASE) + (1 << RATE_W);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             last;

  always_comb begin
    lim   = CNT_W'(QBASE) << rate;
    last  = (cnt_q >= (lim - CNT_W'(1)));
    cnt_d = last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign qtick = last;

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    qtick |=> !qtick) else $error("quarter ticks too close"); // R3
endmodule

// File: rtl/i2cm_ctl.sv
module i2cm_ctl #(
  parameter int RATE_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_master,
  input  logic [RATE_W-1:0] ctl_rate,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              nak_clr,
  input  logic              tx_fail,
  input  logic              ev_nak,
  input  logic              ev_take,
  input  logic              ev_drop,
  output logic              master_q,
  output logic [RATE_W-1:0] rate_q,
  output logic              pend_q,
  output logic [DATA_W-1:0] txd_q,
  output logic              nakif_q
);
  logic              master_d, pend_d, nakif_d;
  logic [RATE_W-1:0] rate_d;
  logic [DATA_W-1:0] txd_d;

  always_comb begin
    master_d = master_q;
    if (tx_fail || ev_nak) master_d = 1'b0;
    else if (ctl_wr)       master_d = ctl_master;

    rate_d = ctl_wr ? ctl_rate : rate_q;

    pend_d = pend_q;
    if (tx_fail)                pend_d = 1'b0;
    else if (tx_wr)             pend_d = 1'b1;
    else if (ev_take || ev_drop) pend_d = 1'b0;

    txd_d = tx_wr ? tx_data : txd_q;

    nakif_d = nakif_q;
    if (ev_nak)       nakif_d = 1'b1;
    else if (nak_clr) nakif_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      rate_q   <= '0;
      pend_q   <= 1'b0;
      txd_q    <= '0;
      nakif_q  <= 1'b0;
    end else begin
      master_q <= master_d;
      rate_q   <= rate_d;
      pend_q   <= pend_d;
      txd_q    <= txd_d;
      nakif_q  <= nakif_d;
    end
  end

  AST_NAK_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nak |=> (!master_q && nakif_q)) else $error("nak did not end master"); // R6
  AST_NAKIF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (nakif_q && !nak_clr) |=> nakif_q) else $error("nak flag lost"); // R7
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qtick,
  input  logic              master,
  input  logic              pend,
  input  logic [DATA_W-1:0] txd,
  input  logic [DATA_W-2:0] addr,
  input  logic              rw,
  input  logic              sda_in,
  input  logic              tx_fail,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              byte_done,
  output logic              ev_nak,
  output logic              ev_take,
  output logic              ev_drop
);
  localparam int BW       = $clog2(DATA_W + 1);
  localparam int ACK_SLOT = DATA_W;

  seq_st_t           st_q, st_d;
  logic [1:0]        ph_q, ph_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              ack_q, ack_d;
  logic              sda_q, sda_d, scl_q, scl_d;
  logic              done_q, end_byte;
  logic              in_ack;

  assign in_ack = (bit_q == BW'(ACK_SLOT));

  always_comb begin
    st_d = st_q; ph_d = ph_q; bit_d = bit_q; sh_d = sh_q;
    ack_d = ack_q; sda_d = sda_q; scl_d = scl_q;
    ev_nak = 1'b0; ev_take = 1'b0; ev_drop = 1'b0; end_byte = 1'b0;
    case (st_q)
      ST_IDLE: begin
        sda_d = 1'b0;
        scl_d = 1'b0;
        if (qtick && master) begin
          st_d = ST_START;
          ph_d = 2'd0;
        end
      end
      ST_START: if (qtick) begin
        if (ph_q == 2'd0) begin
          sda_d = 1'b1;
          ph_d  = 2'd1;
        end else begin
          scl_d = 1'b1;
          st_d  = ST_BIT;
          ph_d  = 2'd0;
          bit_d = '0;
          sh_d  = {addr, rw};
        end
      end
      ST_BIT: if (qtick) begin
        case (ph_q)
          2'd0: begin
            sda_d = in_ack ? 1'b0 : ~sh_q[DATA_W-1];
            ph_d  = 2'd1;
          end
          2'd1: begin
            scl_d = 1'b0;
            if (in_ack) ack_d = sda_in;
            ph_d  = 2'd2;
          end
          2'd2: ph_d = 2'd3;
          default: begin
            scl_d = 1'b1;
            ph_d  = 2'd0;
            if (!in_ack) begin
              sh_d  = sh_q << 1;
              bit_d = bit_q + BW'(1);
            end else begin
              end_byte = 1'b1;
              if (ack_q) begin
                ev_nak  = 1'b1;
                ev_drop = 1'b1;
                st_d    = ST_STOP;
              end else if (!master) begin
                ev_drop = 1'b1;
                st_d    = ST_STOP;
              end else if (pend) begin
                ev_take = 1'b1;
                sh_d    = txd;
                bit_d   = '0;
              end else begin
                st_d = ST_WAIT;
              end
            end
          end
        endcase
      end
      ST_WAIT: if (qtick) begin
        ph_d = 2'd0;
        if (!master) begin
          ev_drop = 1'b1;
          st_d    = ST_STOP;
        end else if (pend) begin
          ev_take = 1'b1;
          sh_d    = txd;
          bit_d   = '0;
          st_d    = ST_BIT;
        end
      end
      ST_STOP: if (qtick) begin
        case (ph_q)
          2'd0: begin
            sda_d = 1'b1;
            ph_d  = 2'd1;
          end
          2'd1: begin
            scl_d = 1'b0;
            ph_d  = 2'd2;
          end
          default: begin
            sda_d = 1'b0;
            st_d  = ST_IDLE;
            ph_d  = 2'd0;
          end
        endcase
      end
      default: st_d = ST_IDLE;
    endcase
    if (tx_fail) begin
      st_d  = ST_IDLE;
      ph_d  = 2'd0;
      sda_d = 1'b0;
      scl_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= 2'd0;
      bit_q  <= '0;
      sh_q   <= '0;
      ack_q  <= 1'b0;
      sda_q  <= 1'b0;
      scl_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      ack_q  <= ack_d;
      sda_q  <= sda_d;
      scl_q  <= scl_d;
      done_q <= end_byte;
    end
  end

  assign sda_oe    = sda_q;
  assign scl_oe    = scl_q;
  assign byte_done = done_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (!sda_q && !scl_q)) else $error("idle drives a line"); // R1
  AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BIT && $past(st_q) == ST_BIT && !scl_q && !$past(scl_q)) |-> $stable(sda_q))
    else $error("sda moved with scl high"); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done) else $error("byte_done longer than one cycle"); // R5
  AST_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> scl_q) else $error("scl released while waiting"); // R9
  AST_FAIL_FREES_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail |=> (!sda_oe && !scl_oe && st_q == ST_IDLE)) else $error("abort kept lines"); // R10
endmodule

// File: rtl/i2c_mstr_engine.sv
module i2c_mstr_engine #(
  parameter int BASE_DIV = 16,
  parameter int RATE_W   = 3,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_master,
  input  logic [RATE_W-1:0] ctl_rate,
  input  logic [DATA_W-2:0] call_addr,
  input  logic              call_rw,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              nak_clr,
  input  logic              tx_fail,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              master,
  output logic              nakif,
  output logic              byte_done
);
  logic              rs_q1, rs_q2;
  logic              qtick, pend, ev_nak, ev_take, ev_drop;
  logic [RATE_W-1:0] rate;
  logic [DATA_W-1:0] txd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  i2cm_qtick #(.BASE_DIV(BASE_DIV), .RATE_W(RATE_W)) u_tick (
    .clk(clk), .rst_n(rs_q2), .rate(rate), .qtick(qtick)
  );

  i2cm_ctl #(.RATE_W(RATE_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rs_q2), .ctl_wr(ctl_wr), .ctl_master(ctl_master),
    .ctl_rate(ctl_rate), .tx_wr(tx_wr), .tx_data(tx_data), .nak_clr(nak_clr),
    .tx_fail(tx_fail), .ev_nak(ev_nak), .ev_take(ev_take), .ev_drop(ev_drop),
    .master_q(master), .rate_q(rate), .pend_q(pend), .txd_q(txd), .nakif_q(nakif)
  );

  i2cm_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rs_q2), .qtick(qtick), .master(master), .pend(pend),
    .txd(txd), .addr(call_addr), .rw(call_rw), .sda_in(sda_in), .tx_fail(tx_fail),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .byte_done(byte_done),
    .ev_nak(ev_nak), .ev_take(ev_take), .ev_drop(ev_drop)
  );
endmodule

// File: tb/sim_i2c_mstr_engine.sv
module sim_i2c_mstr_engine;
  logic clk = 1'b0;
  logic rst_n;
  logic ctl_wr, ctl_master, call_rw, tx_wr, nak_clr, tx_fail;
  logic [2:0] ctl_rate;
  logic [6:0] call_addr;
  logic [7:0] tx_data;
  logic sda_oe, scl_oe, master, nakif, byte_done;
  logic slv_pull;
  logic sda_in;

  always #5 clk = ~clk;
  assign sda_in = ~(sda_oe | slv_pull);

  i2c_mstr_engine u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_master(ctl_master),
    .ctl_rate(ctl_rate), .call_addr(call_addr), .call_rw(call_rw),
    .tx_wr(tx_wr), .tx_data(tx_data), .nak_clr(nak_clr), .tx_fail(tx_fail),
    .sda_in(sda_in), .sda_oe(sda_oe), .scl_oe(scl_oe), .master(master),
    .nakif(nakif), .byte_done(byte_done)
  );

  int nchk = 0, nerr = 0;
  bit fin = 0;

  // line monitor and acknowledging slave
  logic       mon_clr;
  int         nak_idx;
  int         starts, stops, nb, mbit, ndone;
  logic [7:0] shr;
  logic [7:0] cap [16];
  logic       ackc [16];
  longint     cyc = 0, last_rise, per_min, per_max;
  logic       p_scl, p_sda;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin : mon
    logic scl_l, sda_l;
    scl_l = ~scl_oe;
    sda_l = ~(sda_oe | slv_pull);
    if (mon_clr) begin
      starts = 0; stops = 0; nb = 0; mbit = 0; ndone = 0; shr = '0;
      per_min = 64'd1 << 40; per_max = 0; last_rise = 0;
      slv_pull = 1'b0; p_scl = 1'b1; p_sda = 1'b1;
    end else begin
      if (byte_done) ndone = ndone + 1;
      if (scl_l && p_scl && sda_l != p_sda) begin
        if (!sda_l) begin starts = starts + 1; mbit = 0; end
        else stops = stops + 1;
      end
      if (scl_l && !p_scl) begin
        if (mbit >= 1) begin
          if (cyc - last_rise < per_min) per_min = cyc - last_rise;
          if (cyc - last_rise > per_max) per_max = cyc - last_rise;
        end
        last_rise = cyc;
        if (mbit < 8) begin
          shr = {shr[6:0], sda_l};
          mbit = mbit + 1;
        end else begin
          if (nb < 16) begin cap[nb] = shr; ackc[nb] = sda_l; end
          nb = nb + 1;
          mbit = 0;
        end
      end
      if (!scl_l && p_scl) slv_pull = (mbit == 8) ? (nb != nak_idx) : 1'b0;
      p_scl = scl_l;
      p_sda = ~(sda_oe | slv_pull);
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic m, input logic [2:0] r);
    @(negedge clk); ctl_wr = 1'b1; ctl_master = m; ctl_rate = r;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_tx(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic clr_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (byte_done !== 1'b1);
  endtask

  task automatic wait_stop(input int n);
    while (stops < n) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; ctl_wr = 0; ctl_master = 0; ctl_rate = 0; call_addr = 7'h2A;
    call_rw = 0; tx_wr = 0; tx_data = 0; nak_clr = 0; tx_fail = 0;
    mon_clr = 1'b1; nak_idx = -1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_clr = 1'b0;

    // R1 reset state
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 master", master, 0);
    chk("R1 nakif", nakif, 0);
    chk("R1 byte_done", byte_done, 0);

    // rate sweep: address + one data byte, ended by master clear
    for (int s = 0; s < 8; s++) begin
      logic [7:0] d;
      call_addr = 7'h50 ^ 7'(s);
      call_rw   = s[0];
      d = 8'hA5 ^ 8'(s * 37);
      clr_mon();
      wr_tx(d);
      wr_ctl(1'b1, 3'(s));
      chk("R11 master set", master, 1);
      wait_done();
      wr_ctl(1'b0, 3'(s));
      wait_stop(1);
      chk("R2 address byte", cap[0], {call_addr, call_rw});
      chk("R2 data byte", cap[1], d);
      chk("R8 bytes sent", nb, 2);
      chk("R4 starts", starts, 1);
      chk("R4 stops", stops, 1);
      chk("R3 period min", per_min, 16 << s);
      chk("R3 period max", per_max, 16 << s);
      chk("R5 done pulses", ndone, 2);
      chk("R6 acked", ackc[0] | ackc[1], 0);
      chk("R8 master low", master, 0);
    end

    // R9 wait with empty queue, then feed bytes
    call_addr = 7'h1B; call_rw = 1'b1;
    clr_mon();
    wr_ctl(1'b1, 3'd0);
    wait_done();
    repeat (200) @(negedge clk);
    chk("R9 scl held low", scl_oe, 1);
    chk("R9 only address sent", nb, 1);
    wr_tx(8'h3C);
    wait_done();
    wr_tx(8'hC3);
    wait_done();
    wr_ctl(1'b0, 3'd0);
    wait_stop(1);
    chk("R9 bytes", nb, 3);
    chk("R2 byte1", cap[1], 8'h3C);
    chk("R2 byte2", cap[2], 8'hC3);
    chk("R5 done pulses", ndone, 3);

    // R8 queued byte dropped on master clear
    clr_mon();
    wr_tx(8'h11);
    wr_ctl(1'b1, 3'd0);
    wait_done();
    wr_tx(8'h22);
    wr_ctl(1'b0, 3'd0);
    wait_stop(1);
    chk("R8 in-flight finished", cap[1], 8'h11);
    chk("R8 count", nb, 2);
    wr_ctl(1'b1, 3'd0);
    wait_done();
    repeat (150) @(negedge clk);
    chk("R8 dropped byte absent", nb, 3);
    chk("R8 waiting", scl_oe, 1);
    wr_ctl(1'b0, 3'd0);
    wait_stop(2);
    chk("R8 final count", nb, 3);

    // R6 NAK on address, queued byte dropped
    clr_mon();
    nak_idx = 0;
    wr_tx(8'h77);
    wr_ctl(1'b1, 3'd0);
    wait_stop(1);
    chk("R6 nakif", nakif, 1);
    chk("R6 master cleared", master, 0);
    chk("R6 ack high", ackc[0], 1);
    chk("R6 bytes", nb, 1);
    repeat (200) @(negedge clk);
    chk("R7 nakif sticky", nakif, 1);
    chk("R6 no restart", starts, 1);
    @(negedge clk); nak_clr = 1'b1;
    @(negedge clk); nak_clr = 1'b0;
    chk("R7 nakif cleared", nakif, 0);
    nak_idx = -1;
    wr_ctl(1'b1, 3'd0);
    wait_done();
    repeat (150) @(negedge clk);
    chk("R6 queued byte never sent", nb, 2);
    wr_ctl(1'b0, 3'd0);
    wait_stop(2);

    // R6 NAK on a data byte
    clr_mon();
    nak_idx = 1;
    wr_tx(8'h5A);
    wr_ctl(1'b1, 3'd0);
    wait_done();
    wr_tx(8'h6B);
    wait_stop(1);
    chk("R6 data nak bytes", nb, 2);
    chk("R6 data nak value", cap[1], 8'h5A);
    chk("R6 data nak flag", nakif, 1);
    @(negedge clk); nak_clr = 1'b1;
    @(negedge clk); nak_clr = 1'b0;
    nak_idx = -1;

    // R10 transmit fail
    clr_mon();
    wr_tx(8'h99);
    wr_ctl(1'b1, 3'd0);
    wait_done();
    do @(negedge clk); while (!(scl_oe === 1'b1 && sda_oe === 1'b1));
    tx_fail = 1'b1;
    @(negedge clk); tx_fail = 1'b0;
    chk("R10 sda released", sda_oe, 0);
    chk("R10 scl released", scl_oe, 0);
    chk("R10 master cleared", master, 0);
    repeat (300) @(negedge clk);
    chk("R10 no stop", stops, 0);
    chk("R10 no restart", starts, 1);
    chk("R10 lines idle", scl_oe | sda_oe, 0);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    fin = 1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule